// File: doc/BRIEF.md
# Dual-Issue Pairing Check

This block sits between instruction fetch and two issue ports of a split machine, one port for integer, memory and branch work and one for floating-point arithmetic. Each fetch packet is 64 bits wide and carries two 32-bit instructions. The lower half is the lead instruction and goes to the integer-side port. The upper half is the trailing instruction and goes to the FP port. Every cycle the block decodes both halves into operation classes. It checks their register specifiers against integer and FP scoreboard vectors, checks the busy flags of the four execution resources, and checks whether the trailing instruction depends on the lead one. From this it grants zero, one or both issue slots, always in program order.

The packet arrives on a valid/ready stream. `pkt_ready` is high in the cycle in which the last outstanding instruction of the packet issues, so a packet is taken when `pkt_valid && pkt_ready`. If only the lead instruction issues, the block remembers that the packet has been split. In the following cycles it offers the trailing instruction alone on the FP slot. During that time the source must keep the same packet valid and stable.

A packet of which nothing has issued yet may be replaced or withdrawn, because the block keeps no state for it. Scoreboard and resource flags are plain level inputs. All grants are combinational in the current inputs and the split state.

Top module: `dual_issue_pair`

## Requirements
- R1: After reset the block is in paired mode. While `pkt_valid` is low, `issue_lo`, `issue_hi`, `pkt_ready` and `issue_cnt` are all zero.
- R2: Instruction fields and class codes:
  - Class is bits [31:29] of each half: 0 integer ALU, 1 integer load, 2 integer store, 3 branch, 4 FP load, 5 FP store, 6 FP arithmetic, 7 illegal.
  - Destination is bits [25:21], first source is [20:16] and second source is [15:11].
  - ALU and FP arithmetic use all three specifiers. Loads use destination and first source. Stores and branches use both sources.
  - The FP load destination, the FP store second source and every specifier of FP arithmetic name FP registers. All other specifiers name integer registers.
- R3: In paired mode the lead instruction issues when all of the following hold: its class is 0 to 5, no specifier it uses is marked in its namespace's busy vector, and its resource is free. Resource bits are `res_busy[0]` ALU (class 0), `[1]` memory (classes 1, 2, 4, 5), `[2]` branch (class 3) and `[3]` FP unit (class 6).
- R4: A lead instruction of class 6 or 7 never issues. Nothing issues, the count is 0 and `pkt_ready` stays low.
- R5: In paired mode the trailing instruction issues only when all of the following hold: the lead instruction issues in the same cycle, the trailing instruction is class 6, none of its FP specifiers is busy, `res_busy[3]` is low, and it does not depend on the lead instruction.
- R6: The trailing instruction depends on the lead one when any FP register the lead uses equals any FP register the trailing uses. Equal numbers in different namespaces do not count.
- R7: When only the lead instruction issues, the block enters split mode. In split mode `issue_lo` stays low. The trailing instruction is offered alone, and issues under the checks of R5 except the lead and dependence terms.
- R8: `pkt_ready` is high exactly when the trailing instruction issues. After that the block is back in paired mode for the next packet.
- R9: `issue_cnt` equals the number of grants this cycle. `issue_hi` without `issue_lo` occurs only in split mode.
- R10: A busy destination register blocks an instruction just as a busy source does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | Fetch packet present |
| pkt_ready | output | 1 | Packet fully consumed this cycle |
| pkt_data | input | 64 | Two instructions, lead in [31:0] |
| int_busy | input | 32 | Integer scoreboard, one bit per register |
| fp_busy | input | 32 | FP scoreboard, one bit per register |
| res_busy | input | 4 | Resource busy: ALU, memory, branch, FP unit |
| issue_lo | output | 1 | Lead instruction granted |
| issue_hi | output | 1 | Trailing instruction granted |
| issue_cnt | output | 2 | Instructions consumed this cycle |

## Verification
Every grant, the count and `pkt_ready` depend combinationally on the current inputs, so each result is due in the same cycle as its stimulus. The only registered effect is the split flag, which changes what the next cycle shows. The bench drives each stimulus just after a rising edge and compares at the following falling edge, one expected record per cycle. Split-mode behaviour is therefore checked in the cycle right after the lone lead grant, and again over several cycles while the trailing instruction stays blocked.

// File: rtl/dip_pkg.sv
package dip_pkg;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned SPEC_W = 5;
  localparam int unsigned N_REG  = 1 << SPEC_W;
  localparam int unsigned N_UNIT = 4;
  localparam int unsigned N_SPEC = 3;
  localparam int unsigned N_SLOT = 2;

  // field positions within one instruction
  localparam int unsigned CLS_LO = 29;
  localparam int unsigned DST_LO = 21;
  localparam int unsigned SA_LO  = 16;
  localparam int unsigned SB_LO  = 11;

  typedef enum logic [2:0] {
    CL_ALU = 3'd0,
    CL_LD  = 3'd1,
    CL_ST  = 3'd2,
    CL_BR  = 3'd3,
    CL_FLD = 3'd4,
    CL_FST = 3'd5,
    CL_FOP = 3'd6,
    CL_BAD = 3'd7
  } cls_e;

  typedef enum logic [1:0] {
    UN_ALU = 2'd0,
    UN_MEM = 2'd1,
    UN_BR  = 2'd2,
    UN_FPU = 2'd3
  } unit_e;

  typedef struct packed {
    logic              used;
    logic              fp;
    logic [SPEC_W-1:0] idx;
  } spec_t;

  // spec[0] destination, spec[1] first source, spec[2] second source
  typedef struct packed {
    cls_e                    cls;
    unit_e                   unit;
    logic                    legal;
    spec_t [N_SPEC-1:0]      spec;
  } dec_t;
endpackage

// File: rtl/dip_decode.sv
module dip_decode
  import dip_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output dec_t              dec
);
  logic [SPEC_W-1:0] f_dst, f_sa, f_sb;
  cls_e              cls;

  assign cls   = cls_e'(insn[CLS_LO +: 3]);
  assign f_dst = insn[DST_LO +: SPEC_W];
  assign f_sa  = insn[SA_LO  +: SPEC_W];
  assign f_sb  = insn[SB_LO  +: SPEC_W];

  always_comb begin
    dec       = '0;
    dec.cls   = cls;
    dec.unit  = UN_ALU;
    dec.legal = 1'b1;
    dec.spec[0].idx = f_dst;
    dec.spec[1].idx = f_sa;
    dec.spec[2].idx = f_sb;
    unique case (cls)
      CL_ALU: begin
        dec.unit = UN_ALU;
        dec.spec[0].used = 1'b1;
        dec.spec[1].used = 1'b1;
        dec.spec[2].used = 1'b1;
      end
      CL_LD: begin
        dec.unit = UN_MEM;
        dec.spec[0].used = 1'b1;
        dec.spec[1].used = 1'b1;
      end
      CL_ST: begin
        dec.unit = UN_MEM;
        dec.spec[1].used = 1'b1;
        dec.spec[2].used = 1'b1;
      end
      CL_BR: begin
        dec.unit = UN_BR;
        dec.spec[1].used = 1'b1;
        dec.spec[2].used = 1'b1;
      end
      CL_FLD: begin
        dec.unit = UN_MEM;
        dec.spec[0].used = 1'b1;
        dec.spec[0].fp   = 1'b1;
        dec.spec[1].used = 1'b1;
      end
      CL_FST: begin
        dec.unit = UN_MEM;
        dec.spec[1].used = 1'b1;
        dec.spec[2].used = 1'b1;
        dec.spec[2].fp   = 1'b1;
      end
      CL_FOP: begin
        dec.unit = UN_FPU;
        for (int k = 0; k < N_SPEC; k++) begin
          dec.spec[k].used = 1'b1;
          dec.spec[k].fp   = 1'b1;
        end
      end
      default: begin
        dec.legal = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/dip_hazard.sv
module dip_hazard
  import dip_pkg::*;
(
  input  dec_t              dec,
  input  logic [N_REG-1:0]  int_busy,
  input  logic [N_REG-1:0]  fp_busy,
  input  logic [N_UNIT-1:0] res_busy,
  output logic              blocked
);
  logic [N_SPEC-1:0] hit;

  for (genvar k = 0; k < N_SPEC; k++) begin : g_spec
    assign hit[k] = dec.spec[k].used &
                    (dec.spec[k].fp ? fp_busy[dec.spec[k].idx]
                                    : int_busy[dec.spec[k].idx]);
  end

  assign blocked = res_busy[dec.unit] | (|hit);
endmodule

// File: rtl/dip_depend.sv
module dip_depend
  import dip_pkg::*;
(
  input  dec_t lead,
  input  dec_t trail,
  output logic dep
);
  logic [N_SPEC*N_SPEC-1:0] match;

  for (genvar i = 0; i < N_SPEC; i++) begin : g_lead
    for (genvar j = 0; j < N_SPEC; j++) begin : g_trail
      assign match[i*N_SPEC + j] =
        lead.spec[i].used  & lead.spec[i].fp &
        trail.spec[j].used & trail.spec[j].fp &
        (lead.spec[i].idx == trail.spec[j].idx);
    end
  end

  assign dep = |match;
endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
  import dip_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pkt_valid,
  output logic                       pkt_ready,
  input  logic [N_SLOT*INSN_W-1:0]   pkt_data,
  input  logic [N_REG-1:0]           int_busy,
  input  logic [N_REG-1:0]           fp_busy,
  input  logic [N_UNIT-1:0]          res_busy,
  output logic                       issue_lo,
  output logic                       issue_hi,
  output logic [1:0]                 issue_cnt
);
  dec_t              dec [N_SLOT];
  logic [N_SLOT-1:0] blk;
  logic              dep;
  logic              split_q;
  logic              lead_ok, trail_ok;

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    dip_decode u_dec (
      .insn (pkt_data[s*INSN_W +: INSN_W]),
      .dec  (dec[s])
    );
    dip_hazard u_haz (
      .dec      (dec[s]),
      .int_busy (int_busy),
      .fp_busy  (fp_busy),
      .res_busy (res_busy),
      .blocked  (blk[s])
    );
  end

  dip_depend u_dep (
    .lead  (dec[0]),
    .trail (dec[1]),
    .dep   (dep)
  );

  assign lead_ok  = dec[0].legal && (dec[0].cls != CL_FOP) && !blk[0];
  assign trail_ok = (dec[1].cls == CL_FOP) && !blk[1];

  assign issue_lo  = pkt_valid && !split_q && lead_ok;
  assign issue_hi  = pkt_valid && trail_ok && (split_q || (issue_lo && !dep));
  assign pkt_ready = issue_hi;
  assign issue_cnt = {1'b0, issue_lo} + {1'b0, issue_hi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    split_q <= 1'b0;
    else if (issue_hi)             split_q <= 1'b0;
    else if (issue_lo)             split_q <= 1'b1;
  end
endmodule

// File: rtl/dip_checker.sv
module dip_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        pkt_valid,
  input logic [31:0] lead_word,
  input logic        fpu_busy,
  input logic        issue_lo,
  input logic        issue_hi,
  input logic [1:0]  issue_cnt
);
  logic pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    pend <= 1'b0;
    else if (issue_hi)             pend <= 1'b0;
    else if (issue_lo)             pend <= 1'b1;
  end

  a_r1_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |-> (issue_cnt == 2'd0));

  a_r4_fp_lead_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pend && lead_word[31:29] == 3'd6) |-> !issue_lo);

  a_r5_fpu_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    fpu_busy |-> !issue_hi);

  a_r7_split_no_lead: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !issue_lo);

  a_r9_lone_trail_split: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_hi && !issue_lo) |-> pend);

  a_r9_count_two: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_cnt == 2'd2) |-> (issue_lo && issue_hi && !pend));
endmodule

bind dual_issue_pair dip_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pkt_valid (pkt_valid),
  .lead_word (pkt_data[31:0]),
  .fpu_busy  (res_busy[3]),
  .issue_lo  (issue_lo),
  .issue_hi  (issue_hi),
  .issue_cnt (issue_cnt)
);

// File: tb/test_dual_issue_pair.sv
module test_dual_issue_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pkt_valid = 1'b0;
  logic        pkt_ready;
  logic [63:0] pkt_data = '0;
  logic [31:0] int_busy = '0;
  logic [31:0] fp_busy = '0;
  logic [3:0]  res_busy = '0;
  logic        issue_lo, issue_hi;
  logic [1:0]  issue_cnt;

  typedef struct {
    logic       lo;
    logic       hi;
    logic [1:0] cnt;
    logic       rdy;
    string      tag;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  always #10 clk = ~clk;

  dual_issue_pair i_dual_issue_pair (
    .clk       (clk),
    .rst_n     (rst_n),
    .pkt_valid (pkt_valid),
    .pkt_ready (pkt_ready),
    .pkt_data  (pkt_data),
    .int_busy  (int_busy),
    .fp_busy   (fp_busy),
    .res_busy  (res_busy),
    .issue_lo  (issue_lo),
    .issue_hi  (issue_hi),
    .issue_cnt (issue_cnt)
  );

  function automatic logic [31:0] mk(input logic [2:0] c, input logic [4:0] d,
                                     input logic [4:0] a, input logic [4:0] b);
    mk = {c, 3'b000, d, a, b, 11'd0};
  endfunction

  task automatic drive(input logic v, input logic [31:0] hi_w, input logic [31:0] lo_w,
                       input logic [31:0] ib, input logic [31:0] fb, input logic [3:0] rb,
                       input logic xlo, input logic xhi, input logic [1:0] xcnt,
                       input logic xrdy, input string tag);
    exp_t x;
    @(posedge clk);
    #1;
    pkt_valid = v;
    pkt_data  = {hi_w, lo_w};
    int_busy  = ib;
    fp_busy   = fb;
    res_busy  = rb;
    x.lo = xlo; x.hi = xhi; x.cnt = xcnt; x.rdy = xrdy; x.tag = tag;
    q.push_back(x);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if (issue_lo !== e.lo || issue_hi !== e.hi || issue_cnt !== e.cnt ||
          pkt_ready !== e.rdy) begin
        fails++;
        $display("FAIL %s: got lo=%0b hi=%0b cnt=%0d rdy=%0b, expected lo=%0b hi=%0b cnt=%0d rdy=%0b",
                 e.tag, issue_lo, issue_hi, issue_cnt, pkt_ready, e.lo, e.hi, e.cnt, e.rdy);
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: idle after reset
    drive(0, mk(6,1,2,3), mk(0,1,2,3), 0, 0, 0, 0,0,0,0, "R1 idle after reset");
    // R3 R5 R8 R9: clean pair; also R6 namespaces (r1 vs f1)
    drive(1, mk(6,1,2,3), mk(0,1,2,3), 0, 0, 0, 1,1,2,1, "R5 R6 R9 clean pair");
    // R6: FP load dest feeds trailing source
    drive(1, mk(6,6,4,7), mk(4,4,5,0), 0, 0, 0, 1,0,1,0, "R6 FP load dependence");
    // R7 R8: trailing offered alone
    drive(1, mk(6,6,4,7), mk(4,4,5,0), 0, 0, 0, 0,1,1,1, "R7 split trailing issues");
    // R4: FP arithmetic in lead slot
    drive(1, mk(6,8,9,10), mk(6,1,2,3), 0, 0, 0, 0,0,0,0, "R4 FP op in lead");
    // R4: illegal class 7
    drive(1, mk(6,8,9,10), mk(7,1,2,3), 0, 0, 0, 0,0,0,0, "R4 illegal lead");
    // R3 R2: load needs memory resource (bit 1)
    drive(1, mk(6,8,9,10), mk(1,1,2,0), 0, 0, 4'b0010, 0,0,0,0, "R3 R2 memory busy");
    // R3: busy integer source
    drive(1, mk(6,10,11,12), mk(0,1,2,3), 32'h1 << 3, 0, 0, 0,0,0,0, "R3 source busy");
    // R10: busy integer destination
    drive(1, mk(6,10,11,12), mk(0,9,2,3), 32'h1 << 9, 0, 0, 0,0,0,0, "R10 destination busy");
    // R2 R6: FP busy bits do not block integer lead of same numbers
    drive(1, mk(6,20,21,22), mk(0,4,5,6), 0, (32'h1 << 4) | (32'h1 << 5), 0, 1,1,2,1,
          "R2 R6 namespace separation");
    // R5: FP unit busy
    drive(1, mk(6,8,9,10), mk(3,1,2,0), 0, 0, 4'b1000, 1,0,1,0, "R5 FP unit busy");
    // R7: split, still blocked
    drive(1, mk(6,8,9,10), mk(3,1,2,0), 0, 0, 4'b1000, 0,0,0,0, "R7 split held");
    drive(1, mk(6,8,9,10), mk(3,1,2,0), 0, 0, 4'b0000, 0,1,1,1, "R7 R8 split released");
    // R5: trailing FP source busy
    drive(1, mk(6,1,2,3), mk(2,0,1,2), 0, 32'h1 << 2, 0, 1,0,1,0, "R5 trailing source busy");
    drive(1, mk(6,1,2,3), mk(2,0,1,2), 0, 0, 0, 0,1,1,1, "R7 trailing after split");
    // R6: FP store data register written by trailing
    drive(1, mk(6,5,1,2), mk(5,0,1,5), 0, 0, 0, 1,0,1,0, "R6 FP store dependence");
    drive(1, mk(6,5,1,2), mk(5,0,1,5), 0, 0, 0, 0,1,1,1, "R7 after FP store split");
    // R6: integer r7 vs FP f7 no dependence
    drive(1, mk(6,1,7,7), mk(1,7,1,0), 0, 0, 0, 1,1,2,1, "R6 integer load no dep");
    // R5: trailing slot not FP arithmetic
    drive(1, mk(0,1,2,3), mk(0,1,2,3), 0, 0, 0, 1,0,1,0, "R5 trailing not FP");
    drive(1, mk(0,1,2,3), mk(0,1,2,3), 0, 0, 0, 0,0,0,0, "R7 split trailing ineligible");

    // R1: reset clears split mode
    @(posedge clk);
    #1 rst_n = 1'b0;
    pkt_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    drive(1, mk(0,1,2,3), mk(0,1,2,3), 0, 0, 0, 1,0,1,0, "R1 reset returns paired mode");

    repeat (2) @(posedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule